// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the two timing strobes of a multiplexed external memory bus on a small 8-bit controller. The first is an active-high address-latch strobe, which tells outside logic when to capture the low address byte. The second is an active-low program-store strobe, which is the read strobe for external code memory. The block runs on the oscillator clock and counts a twelve-period machine cycle. Each cycle holds two equal slots, and every strobe pulse sits at a fixed phase within its slot.

The sequencer that issues instructions reports three things for each machine cycle: whether the cycle makes an external data access, whether it reads a code table, and whether code is being fetched from external memory. A one-bit control register, at special-function address 8Eh, can hold the address-latch strobe high in cycles that have no use for it. The external-fetch flag overrides that register. During external data accesses, pulses that would collide with the data transfer are left out.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: While `rstN` is low, `aleOut` is 0, `psenN` is 1 and the suppress bit is 0. After release, the first machine cycle runs with all cycle flags at 0.
- R2: A machine cycle lasts 12 clocks. Both outputs are registered, so clock edge n after reset release (n ≥ 1) presents output phase (n−1) mod 12. In an ordinary cycle `aleOut` is 1 at output phases 0, 1, 6 and 7, and 0 at all other phases. This gives two pulses of two clocks each, one every six clocks.
- R3: In a cycle flagged as an external data access, the pulse at phases 6–7 is left out and the pulse at phases 0–1 is kept.
- R4: When external fetch is flagged and there is no data access, `psenN` is 0 at output phases 3, 4, 5, 9, 10 and 11, and 1 at all other phases.
- R5: In a cycle flagged as an external data access, `psenN` stays 1 for the whole cycle, so both of its assertions are left out.
- R6: When external fetch is not flagged, `psenN` stays 1.
- R7: When the suppress bit is 1 and external fetch, data access and code-table read are all not flagged, `aleOut` is 1 for the whole cycle.
- R8: When the suppress bit is 1 and the cycle is flagged as a data access or a code-table read, `aleOut` follows the pattern of R2 and R3.
- R9: When external fetch is flagged, the suppress bit has no effect on `aleOut`.
- R10: A clock edge with `sfrWe`=1 and `sfrAddr`=8Eh loads `sfrWdata[0]` into the suppress bit. A write to any other address, or with `sfrWe`=0, leaves the bit unchanged.
- R11: The three cycle flags and the suppress bit are sampled at the edge that ends output phase 11, and they hold for the whole machine cycle that follows. A flag that changes in the middle of a cycle has no effect until the next cycle boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; one period is one phase |
| rstN | input | 1 | Active-low synchronous reset |
| xdataAcc | input | 1 | The coming machine cycle makes an external data access |
| codeTblRd | input | 1 | The coming machine cycle reads a code table |
| extFetch | input | 1 | Code is being fetched from external memory |
| sfrWe | input | 1 | Write strobe for special-function registers |
| sfrAddr | input | 8 | Write address for special-function registers |
| sfrWdata | input | 8 | Write data; bit 0 is the suppress bit at 8Eh |
| aleOut | output | 1 | Address-latch strobe, active high |
| psenN | output | 1 | Program-store strobe, active low |

## Verification
The assertions assume that the phase sequencer and the flag latch change only at clock edges. They take the cycle flags as already stable, so none of them depends on when the flags arrive. They also assume that the external-fetch override and the fetch-strobe windows never meet a raised latch strobe. The stimulus changes the flags in the clock just before a cycle boundary. It also makes one deliberate change in the middle of a cycle, so that sampling only at the boundary is exercised.

// File: rtl/esg_pkg.sv
package esg_pkg;

  // Phase windows decoded by the sequencer for the current phase
  typedef struct packed {
    logic aleWin;   // inside any latch-strobe window
    logic aleSkip;  // inside the window that a data access drops
    logic psenWin;  // inside any fetch-strobe window
    logic wrap;     // last phase of the machine cycle
  } strobe_t;

  // Flags latched at the machine-cycle boundary
  typedef struct packed {
    logic xdata;
    logic ctbl;
    logic ext;
    logic dis;
  } cyc_flags_t;

endpackage

// File: rtl/esg_phase_ctrl.sv
module esg_phase_ctrl
  import esg_pkg::*;
#(
  parameter int unsigned CYC_LEN   = 12,
  parameter int unsigned SLOTS     = 2,
  parameter int unsigned ALE_OFS   = 0,
  parameter int unsigned ALE_LEN   = 2,
  parameter int unsigned PSEN_OFS  = 3,
  parameter int unsigned PSEN_LEN  = 3,
  parameter int unsigned SKIP_SLOT = 1
) (
  input  logic    clk,
  input  logic    rstN,
  output strobe_t strb
);

  localparam int unsigned SLOT_LEN = CYC_LEN / SLOTS;
  localparam int unsigned PH_W     = $clog2(CYC_LEN);
  localparam int unsigned LAST     = CYC_LEN - 1;

  logic [PH_W-1:0]  phase;
  int unsigned      phInt;
  logic [SLOTS-1:0] aleHit;
  logic [SLOTS-1:0] psenHit;

  assign phInt = 32'(phase);

  always_ff @(posedge clk) begin
    if (!rstN)               phase <= '0;
    else if (phInt == LAST)  phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  // One window pair per slot; unsigned wrap keeps "before start" out of range
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int unsigned BASE = s * SLOT_LEN;
    int unsigned aleRel;
    int unsigned psenRel;
    assign aleRel     = phInt - (BASE + ALE_OFS);
    assign psenRel    = phInt - (BASE + PSEN_OFS);
    assign aleHit[s]  = aleRel < ALE_LEN;
    assign psenHit[s] = psenRel < PSEN_LEN;
  end

  assign strb.aleWin  = |aleHit;
  assign strb.aleSkip = aleHit[SKIP_SLOT];
  assign strb.psenWin = |psenHit;
  assign strb.wrap    = (phInt == LAST);

  // R2
  wrap_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrap |=> !strb.wrap);

  // R2
  ale_psen_disjoint_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.aleWin && strb.psenWin));

endmodule

// File: rtl/esg_strobe_dp.sv
module esg_strobe_dp
  import esg_pkg::*;
#(
  parameter logic [7:0] SFR_ADDR = 8'h8E,
  parameter int unsigned DIS_BIT = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic       xdataAcc,
  input  logic       codeTblRd,
  input  logic       extFetch,
  input  logic       sfrWe,
  input  logic [7:0] sfrAddr,
  input  logic [7:0] sfrWdata,
  output logic       aleOut,
  output logic       psenN
);

  logic       aleDis;
  cyc_flags_t cyc;
  logic       suppress;
  logic       aleNext;
  logic       psenNext;

  // Suppress bit, written through the register port
  always_ff @(posedge clk) begin
    if (!rstN)                              aleDis <= 1'b0;
    else if (sfrWe && sfrAddr == SFR_ADDR)  aleDis <= sfrWdata[DIS_BIT];
  end

  // Flags hold for a whole machine cycle
  always_ff @(posedge clk) begin
    if (!rstN)          cyc <= '0;
    else if (strb.wrap) cyc <= '{xdata: xdataAcc, ctbl: codeTblRd,
                                 ext: extFetch, dis: aleDis};
  end

  always_comb begin
    suppress = cyc.dis && !cyc.ext && !cyc.xdata && !cyc.ctbl;
    aleNext  = suppress | (strb.aleWin & ~(cyc.xdata & strb.aleSkip));
    psenNext = ~(strb.psenWin & cyc.ext & ~cyc.xdata);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aleOut <= 1'b0;
      psenN  <= 1'b1;
    end else begin
      aleOut <= aleNext;
      psenN  <= psenNext;
    end
  end

  // R10
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sfrWe || sfrAddr != SFR_ADDR) |=> $stable(aleDis));

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrap |=> $stable(cyc));

  // R7
  ale_parked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc.dis && !cyc.ext && !cyc.xdata && !cyc.ctbl) |=> aleOut);

  // R6
  psen_internal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cyc.ext && !strb.wrap) |=> psenN);

endmodule

// File: rtl/ext_bus_strobe_gen.sv
module ext_bus_strobe_gen
  import esg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       xdataAcc,
  input  logic       codeTblRd,
  input  logic       extFetch,
  input  logic       sfrWe,
  input  logic [7:0] sfrAddr,
  input  logic [7:0] sfrWdata,
  output logic       aleOut,
  output logic       psenN
);

  strobe_t strb;

  esg_phase_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb)
  );

  esg_strobe_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .xdataAcc  (xdataAcc),
    .codeTblRd (codeTblRd),
    .extFetch  (extFetch),
    .sfrWe     (sfrWe),
    .sfrAddr   (sfrAddr),
    .sfrWdata  (sfrWdata),
    .aleOut    (aleOut),
    .psenN     (psenN)
  );

  // R2
  ale_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aleOut) |=> aleOut);

  // R4
  psen_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(psenN) |=> !psenN);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(aleOut && !psenN));

endmodule

// File: tb/tb_ext_bus_strobe_gen.sv
module tb_ext_bus_strobe_gen;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       xdataAcc = 1'b0;
  logic       codeTblRd = 1'b0;
  logic       extFetch = 1'b0;
  logic       sfrWe = 1'b0;
  logic [7:0] sfrAddr = 8'h00;
  logic [7:0] sfrWdata = 8'h00;
  logic       aleOut;
  logic       psenN;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference model state
  int    mph = 0;
  bit    mx = 0, mc = 0, me = 0, md = 0;
  bit    mDis = 0;
  bit    expAle = 0, expPsenN = 1;
  string aleTag = "R1", psenTag = "R1";
  string scen = "R2";

  ext_bus_strobe_gen dut (
    .clk(clk), .rstN(rstN), .xdataAcc(xdataAcc), .codeTblRd(codeTblRd),
    .extFetch(extFetch), .sfrWe(sfrWe), .sfrAddr(sfrAddr),
    .sfrWdata(sfrWdata), .aleOut(aleOut), .psenN(psenN));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural model: what each phase should show, from the requirements
  always @(posedge clk) begin
    if (!rstN) begin
      mph <= 0; mx <= 0; mc <= 0; me <= 0; md <= 0; mDis <= 0;
      expAle <= 0; expPsenN <= 1; aleTag <= "R1"; psenTag <= "R1";
    end else begin
      if (md && !me && !mx && !mc) begin
        expAle <= 1; aleTag <= "R7";
      end else begin
        expAle <= ((mph % 6) < 2) && !(mx && mph >= 6);
        aleTag <= me && md ? "R9" : md ? "R8" : mx ? "R3" : "R2";
      end
      expPsenN <= !(me && !mx && (mph % 6) >= 3);
      psenTag  <= !me ? "R6" : mx ? "R5" : "R4";
      if (sfrWe && sfrAddr == 8'h8E) mDis <= sfrWdata[0];
      if (mph == 11) begin
        mx <= xdataAcc; mc <= codeTblRd; me <= extFetch; md <= mDis;
        mph <= 0;
      end else mph <= mph + 1;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      total++;
      if (aleOut !== expAle) begin
        bad++;
        $display("FAIL %s (%s) aleOut phase-model mismatch: actual=%0b expected=%0b",
                 aleTag, scen, aleOut, expAle);
      end
      total++;
      if (psenN !== expPsenN) begin
        bad++;
        $display("FAIL %s (%s) psenN mismatch: actual=%0b expected=%0b",
                 psenTag, scen, psenN, expPsenN);
      end
    end
  end

  // Set flags in the clock before a boundary; they govern the next cycle
  task automatic cycle(input bit x, input bit c, input bit e);
    @(negedge clk);
    while (mph != 11) @(negedge clk);
    xdataAcc = x; codeTblRd = c; extFetch = e;
  endtask

  task automatic sfrWrite(input logic [7:0] a, input logic [7:0] d, input bit we);
    @(negedge clk);
    sfrWe = we; sfrAddr = a; sfrWdata = d;
    @(negedge clk);
    sfrWe = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    total++;
    if (aleOut !== 1'b0 || psenN !== 1'b1) begin
      bad++;
      $display("FAIL R1 reset outputs: actual=%0b/%0b expected=0/1", aleOut, psenN);
    end
    rstN = 1;
    scen = "R2";  cycle(0, 0, 0); cycle(0, 0, 0);
    scen = "R4";  cycle(0, 0, 1); cycle(0, 0, 1);
    scen = "R5";  cycle(1, 0, 1); cycle(0, 1, 1);
    scen = "R3";  cycle(1, 0, 0); cycle(0, 0, 0);
    scen = "R10"; sfrWrite(8'h8E, 8'h01, 1);
    scen = "R7";  cycle(0, 0, 0); cycle(0, 0, 0);
    scen = "R8";  cycle(0, 1, 0); cycle(1, 0, 0); cycle(1, 1, 0);
    scen = "R9";  cycle(0, 0, 1); cycle(1, 0, 1);
    scen = "R10"; cycle(0, 0, 0);
    sfrWrite(8'h8F, 8'h00, 1);
    sfrWrite(8'h8E, 8'h00, 0);
    sfrWrite(8'h0E, 8'h00, 1);
    cycle(0, 0, 0); cycle(0, 0, 0);
    // R11: flag changes mid-cycle must wait for the boundary
    scen = "R11";
    @(negedge clk);
    while (mph != 5) @(negedge clk);
    xdataAcc = 1; extFetch = 1;
    cycle(0, 0, 0);
    sfrWrite(8'h8E, 8'hFE, 1);
    cycle(0, 0, 0); cycle(0, 0, 1);
    scen = "R2";  cycle(0, 0, 0); cycle(0, 0, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule